// File: doc/BRIEF.md
# Trace Memory Fill Monitor

This block follows the write position inside an external trace memory that occupies a programmed address window, and produces three trigger outputs. One mirrors the full flag of the internal main trace queue. One reports that the external window is exhausted. One reports that the window has filled past a programmable watermark. Trace clients normally use the last two as stall or suppress requests. The watermark is typically set to about nine tenths of the window size.

Each accepted write strobe advances a fill count, which is the offset from the window base. The block also drives the next write address, which is base plus fill. When the last location of the window is written, the overwrite control decides the outcome. If overwrite is set, the address returns to the base and the full trigger pulses for one cycle. If overwrite is clear, the block holds the full trigger and a stall output high and refuses further strobes until software clears it. A clear input returns the pointer to the base and drops every trigger.

Top module: `trace_fill_monitor`

## Requirements
- R1: After reset, fill_o is 0 and q_full_o, ext_full_o, mark_o and stall_o are all low.
- R2: A write strobe accepted at a clock edge raises fill_o by one after that edge, and addr_o always equals base_i + fill_o.
- R3: mark_o goes high after the edge of an accepted write whose new fill count is greater than or equal to mark_i. It stays high until a wrap, a clear or a reset.
- R4: With overwrite_i = 1, an accepted write that would make the fill equal to size_i sets fill_o to 0 and clears mark_o. It also drives ext_full_o high for exactly one cycle, and later writes continue from the base.
- R5: With overwrite_i = 0, an accepted write that makes the fill equal to size_i leaves fill_o = size_i and raises ext_full_o and stall_o. Both stay high until a clear or a reset.
- R6: While stall_o is high, write strobes are ignored, so fill_o and addr_o do not change.
- R7: q_full_o equals queue_full_i as sampled at the previous clock edge.
- R8: clear_i at an edge sets fill_o to 0 and drops q_full_o, ext_full_o, mark_o and stall_o after that edge. It takes priority over a write in the same cycle. size_i must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Software clear of pointer and triggers |
| wr_i | input | 1 | Write strobe into the external memory |
| base_i | input | ADDR_W | First address of the window |
| size_i | input | ADDR_W | Number of locations in the window |
| mark_i | input | ADDR_W | Watermark fill level |
| overwrite_i | input | 1 | 1: wrap to base when full, 0: stall |
| queue_full_i | input | 1 | Full flag of the internal queue |
| addr_o | output | ADDR_W | Address for the next write |
| fill_o | output | ADDR_W | Locations written since base |
| q_full_o | output | 1 | Internal queue full trigger |
| ext_full_o | output | 1 | External memory full trigger |
| mark_o | output | 1 | Watermark reached trigger |
| stall_o | output | 1 | Writes refused, memory exhausted |

## Verification
The fill count is the only wide piece of state, and addr_o exposes it on every cycle. A wrong increment or a missed wrap therefore appears at the ports one clock after the strobe that caused it. A watermark flag that is not sticky, or that is cleared at the wrong time, shows up on the first idle cycle or the first write after the wrap. A stall that leaks strobes moves addr_o on the very next edge. The checks walk a full overwrite cycle and then a stalled fill, and they sample every output after each edge.

// File: rtl/trace_fill_monitor.sv
module trace_fill_monitor #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [ADDR_W-1:0] mark_i,
  input  logic              overwrite_i,
  input  logic              queue_full_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] fill_o,
  output logic              q_full_o,
  output logic              ext_full_o,
  output logic              mark_o,
  output logic              stall_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] fill_q;
  logic full_q, wrap_q, mark_q, qf_q;

  wire              take     = wr_i & ~full_q;
  wire [ADDR_W-1:0] fill_inc = fill_q + ONE;
  wire              at_end   = (fill_inc == size_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      full_q <= 1'b0;
      wrap_q <= 1'b0;
      mark_q <= 1'b0;
      qf_q   <= 1'b0;
    end else if (clear_i) begin
      fill_q <= '0;
      full_q <= 1'b0;
      wrap_q <= 1'b0;
      mark_q <= 1'b0;
      qf_q   <= 1'b0;
    end else begin
      qf_q   <= queue_full_i;
      wrap_q <= 1'b0;
      if (take) begin
        if (at_end && overwrite_i) begin
          fill_q <= '0;
          wrap_q <= 1'b1;
          mark_q <= 1'b0;
        end else begin
          fill_q <= fill_inc;
          if (at_end) full_q <= 1'b1;
          if (fill_inc >= mark_i) mark_q <= 1'b1;
        end
      end
    end
  end

  assign fill_o     = fill_q;
  assign addr_o     = base_i + fill_q;
  assign q_full_o   = qf_q;
  assign ext_full_o = full_q | wrap_q;
  assign mark_o     = mark_q;
  assign stall_o    = full_q;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !clear_i) |=> (fill_o == $past(fill_o)));

  // R7
  qfull_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (q_full_o == $past(queue_full_i)));

  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (fill_o == '0 && !q_full_o && !ext_full_o && !mark_o && !stall_o));

  // R3
  mark_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mark_o) |-> (fill_o == '0));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !stall_o && !clear_i && (fill_o + ONE != size_i)) |=> (fill_o == $past(fill_o) + ONE));

  // R5
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> ext_full_o);
endmodule

// File: tb/trace_fill_monitor_tb.sv
module trace_fill_monitor_tb_top;
  localparam int W = 16;
  localparam logic [W-1:0] BASE = 16'h1000;

  logic clk = 1'b0, rst_n = 1'b0, clear_i = 1'b0, wr_i = 1'b0;
  logic overwrite_i = 1'b1, queue_full_i = 1'b0;
  logic [W-1:0] base_i = BASE, size_i = 16'd8, mark_i = 16'd6;
  logic [W-1:0] addr_o, fill_o;
  logic q_full_o, ext_full_o, mark_o, stall_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  trace_fill_monitor #(.ADDR_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .wr_i(wr_i), .base_i(base_i),
    .size_i(size_i), .mark_i(mark_i), .overwrite_i(overwrite_i),
    .queue_full_i(queue_full_i), .addr_o(addr_o), .fill_o(fill_o),
    .q_full_o(q_full_o), .ext_full_o(ext_full_o), .mark_o(mark_o), .stall_o(stall_o));

  // vector: wr, fill, mark, full, stall (overwrite mode, size 8, mark 6)
  localparam int NV = 11;
  localparam logic [7:0] VEC [NV] = '{
    8'b1_0001_000, 8'b1_0010_000, 8'b1_0011_000, 8'b0_0011_000,
    8'b1_0100_000, 8'b1_0101_000, 8'b1_0110_100, 8'b1_0111_100,
    8'b1_0000_010, 8'b0_0000_000, 8'b1_0001_000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic clr);
    wr_i = wr; clear_i = clr;
    @(posedge clk); @(negedge clk);
    wr_i = 1'b0; clear_i = 1'b0;
  endtask

  task automatic state(input string req, input int f, input logic m, input logic fu, input logic st);
    chk(req, fill_o, f);
    chk(req, addr_o, BASE + f);
    chk(req, mark_o, m);
    chk(req, ext_full_o, fu);
    chk(req, stall_o, st);
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    state("R1", 0, 0, 0, 0);
    chk("R1", q_full_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 table walk in overwrite mode
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7], 1'b0);
      state(VEC[i][2:1] == 2'b01 ? "R4" : (VEC[i][3] ? "R3" : "R2"),
            int'(VEC[i][6:3]), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R8 clear, then non-overwrite fill (R5)
    step(1'b0, 1'b1);
    state("R8", 0, 0, 0, 0);
    overwrite_i = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      step(1'b1, 1'b0);
      state(k == 8 ? "R5" : (k >= 6 ? "R3" : "R2"), k, k >= 6, k == 8, k == 8);
    end
    // R6 strobes ignored while stalled
    step(1'b1, 1'b0);
    state("R6", 8, 1, 1, 1);
    step(1'b1, 1'b0);
    state("R6", 8, 1, 1, 1);
    step(1'b0, 1'b0);
    state("R5", 8, 1, 1, 1);

    // R7 queue full copy
    queue_full_i = 1'b1;
    chk("R7", q_full_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R7", q_full_o, 1);
    queue_full_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7", q_full_o, 0);
    queue_full_i = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7", q_full_o, 1);

    // R8 clear with a write in the same cycle
    step(1'b1, 1'b1);
    state("R8", 0, 0, 0, 0);
    chk("R8", q_full_o, 0);
    step(1'b1, 1'b0);
    state("R8", 1, 0, 0, 0);
    chk("R7", q_full_o, 1);

    // R4 wrap with size 1 in overwrite mode: every write pulses full
    overwrite_i = 1'b1; size_i = 16'd1; queue_full_i = 1'b0;
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    state("R4", 0, 0, 1, 0);
    step(1'b0, 1'b0);
    state("R4", 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule